// File: doc/BRIEF.md
# Hold/Acknowledge Bus Ownership Arbiter

This block settles which side drives a shared expansion bus: the local controller or an external device. Ownership passes through a two-wire handshake: one hold-request input and one hold-acknowledge output. A strap pin is captured while reset is held, and it fixes the role of the block until the next reset. The captured value is available as a read-only status bit.

In arbiter role the local side leaves reset owning the bus. It hands the bus to an outside requester only when its local DMA engine has no expansion-bus transfer pending and is not inside a frame of a block transfer. In slave role the two wires swap meaning. The output becomes the local request, and the input becomes the external grant. The block turns on its bus drivers only after that grant arrives.

The outputs are output-enable vectors for the host-port pins and for the I/O-port pins, a permission signal that tells the DMA engine it may start transfers, and the handshake output. No data flows through the block. All of its pins are plain control and status levels, so there are no valid/ready streams and no back-pressure rules.

Top module: `xbo_arbiter`

## Requirements
- R1: While `rst` is high, `strap_arb_en` is captured into `arb_mode`. 1 means arbiter role and 0 means slave role. Changes on `strap_arb_en` after reset has been released leave `arb_mode` unchanged.
- R2: On leaving reset in arbiter role, `host_oe` is all ones, `local_go` is 1 and `hold_out` is 0. On leaving reset in slave role, `host_oe` is all zeros, `local_go` is 0 and `hold_out` is 0.
- R3: In arbiter role, `hold_out` never rises unless the synchronized `hold_in` is high. When the block is idle, a `hold_in` rising between clock edges makes `hold_out` high after the third following rising edge.
- R4: In arbiter role, no grant is given while `dma_pending` is high. Once `dma_pending` falls with the request still held, `hold_out` rises on the next rising edge.
- R5: In arbiter role, no grant is given while `dma_in_frame` is high. The grant comes on the first rising edge that sees the frame gap.
- R6: While the bus is granted away in arbiter role (`hold_out` = 1), `host_oe` is all zeros and `local_go` is 0.
- R7: In arbiter role, when `hold_in` falls, `hold_out` falls after the third following rising edge while `host_oe` stays off. On the next edge, `host_oe` returns to all ones and `local_go` returns to 1.
- R8: In slave role, a high `dma_pending` makes `hold_out` high on the next edge. `host_oe` stays off until the synchronized `hold_in` is high, and it turns on after the third edge following the rise of `hold_in`.
- R9: In slave role, the owned bus is released only when both `dma_pending` and `dma_in_frame` are low. On that edge `hold_out`, `host_oe` and `local_go` all go to 0. A new request is raised only after `hold_in` has been seen low.
- R10: `io_oe` is all ones from the first edge after reset release onward, whatever the ownership state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; captures the strap |
| strap_arb_en | input | 1 | Role strap, sampled during reset (1 = arbiter) |
| hold_in | input | 1 | Asynchronous handshake input: request (arbiter role) or grant (slave role) |
| dma_pending | input | 1 | Local transfer to the expansion bus is pending |
| dma_in_frame | input | 1 | Block transfer is inside a frame (release forbidden) |
| hold_out | output | 1 | Handshake output: acknowledge (arbiter role) or request (slave role) |
| arb_mode | output | 1 | Read-only captured role |
| local_go | output | 1 | Local transfers may proceed |
| host_oe | output | HOST_OE_W | Host-port output enables |
| io_oe | output | IO_OE_W | I/O-port output enables (strobes, selects, clock) |

## Verification
The hardest state to reach from the pins is a slave-role release that happens while the external grant is still high and a new local request is already pending. Only this situation shows that the block does not raise its request again before it has seen the grant drop. The bench holds `hold_in` high after the release edge and raises `dma_pending` again. It confirms that `hold_out` stays low over several cycles, then drops `hold_in` and counts the exact edge on which the request comes back. The grant-blocking cases of the arbiter role are reached by raising `hold_in` while a pending request or a frame is already held. The bench then counts the edge on which the blocking input clears.

// File: rtl/xbo_pkg.sv
package xbo_pkg;
  typedef enum logic [1:0] {
    ST_OWNED   = 2'd0,
    ST_WAITB   = 2'd1,
    ST_GRANTED = 2'd2,
    ST_RECLAIM = 2'd3
  } xbo_state_t;

  typedef struct packed {
    logic drive;
    logic go;
    logic hold;
  } xbo_ctl_t;
endpackage

// File: rtl/xbo_sync.sv
module xbo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/xbo_fsm.sv
module xbo_fsm
  import xbo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strap,
  input  logic req_s,
  input  logic pend,
  input  logic in_frame,
  output logic mode,
  output logic drive,
  output logic go,
  output logic hold
);
  xbo_state_t state_q, state_d;
  logic       mode_q;
  logic       gap_ok;
  xbo_ctl_t   ctl;

  assign gap_ok = !pend && !in_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= strap;
      state_q <= strap ? ST_OWNED : ST_GRANTED;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    state_d = state_q;
    if (mode_q) begin
      unique case (state_q)
        ST_OWNED:   if (req_s) state_d = gap_ok ? ST_GRANTED : ST_WAITB;
        ST_WAITB:   if (!req_s) state_d = ST_OWNED;
                    else if (gap_ok) state_d = ST_GRANTED;
        ST_GRANTED: if (!req_s) state_d = ST_RECLAIM;
        ST_RECLAIM: state_d = ST_OWNED;
        default:    state_d = ST_OWNED;
      endcase
    end else begin
      unique case (state_q)
        ST_GRANTED: if (pend) state_d = ST_WAITB;
        ST_WAITB:   if (req_s) state_d = ST_OWNED;
        ST_OWNED:   if (gap_ok) state_d = ST_RECLAIM;
        ST_RECLAIM: if (!req_s) state_d = ST_GRANTED;
        default:    state_d = ST_GRANTED;
      endcase
    end
  end

  always_comb begin
    ctl = '{drive: 1'b0, go: 1'b0, hold: 1'b0};
    if (mode_q) begin
      unique case (state_q)
        ST_OWNED:   ctl = '{drive: 1'b1, go: 1'b1, hold: 1'b0};
        ST_WAITB:   ctl = '{drive: 1'b1, go: 1'b1, hold: 1'b0};
        ST_GRANTED: ctl = '{drive: 1'b0, go: 1'b0, hold: 1'b1};
        default:    ctl = '{drive: 1'b0, go: 1'b0, hold: 1'b0};
      endcase
    end else begin
      unique case (state_q)
        ST_WAITB:   ctl = '{drive: 1'b0, go: 1'b0, hold: 1'b1};
        ST_OWNED:   ctl = '{drive: 1'b1, go: 1'b1, hold: 1'b1};
        default:    ctl = '{drive: 1'b0, go: 1'b0, hold: 1'b0};
      endcase
    end
  end

  assign mode  = mode_q;
  assign drive = ctl.drive;
  assign go    = ctl.go;
  assign hold  = ctl.hold;

  // R3
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && $rose(hold)) |-> $past(req_s));

  // R4 R5
  grant_at_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && $rose(hold)) |-> $past(gap_ok));

  // R1
  mode_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));

  // R9
  slave_rerequest_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && $fell(hold)) |=> !hold);
endmodule

// File: rtl/xbo_drive.sv
module xbo_drive #(
  parameter int HOST_W = 16,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive,
  output logic [HOST_W-1:0] host_oe,
  output logic [IO_W-1:0]   io_oe
);
  logic io_on_q;

  always_ff @(posedge clk) begin
    if (rst) io_on_q <= 1'b0;
    else     io_on_q <= 1'b1;
  end

  generate
    for (genvar i = 0; i < HOST_W; i++) begin : g_host
      assign host_oe[i] = drive;
    end
    for (genvar j = 0; j < IO_W; j++) begin : g_io
      assign io_oe[j] = io_on_q;
    end
  endgenerate

  // R10
  io_always_on_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (io_oe == {IO_W{1'b1}}));
endmodule

// File: rtl/xbo_arbiter.sv
module xbo_arbiter #(
  parameter int HOST_OE_W   = 16,
  parameter int IO_OE_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strap_arb_en,
  input  logic                 hold_in,
  input  logic                 dma_pending,
  input  logic                 dma_in_frame,
  output logic                 hold_out,
  output logic                 arb_mode,
  output logic                 local_go,
  output logic [HOST_OE_W-1:0] host_oe,
  output logic [IO_OE_W-1:0]   io_oe
);
  localparam logic [HOST_OE_W-1:0] HOST_ALL = {HOST_OE_W{1'b1}};

  logic req_s;
  logic drive;

  xbo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (hold_in),
    .q_sync  (req_s)
  );

  xbo_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .strap    (strap_arb_en),
    .req_s    (req_s),
    .pend     (dma_pending),
    .in_frame (dma_in_frame),
    .mode     (arb_mode),
    .drive    (drive),
    .go       (local_go),
    .hold     (hold_out)
  );

  xbo_drive #(.HOST_W(HOST_OE_W), .IO_W(IO_OE_W)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .drive   (drive),
    .host_oe (host_oe),
    .io_oe   (io_oe)
  );

  // R6
  granted_tristate_chk: assert property (@(posedge clk) disable iff (rst)
    (arb_mode && hold_out) |-> (host_oe == '0 && !local_go));

  // R7
  reclaim_order_chk: assert property (@(posedge clk) disable iff (rst)
    (arb_mode && $fell(hold_out)) |-> (host_oe == '0) ##1 (host_oe == HOST_ALL && local_go));

  // R8
  slave_drive_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!arb_mode && host_oe != '0) |-> hold_out);
endmodule

// File: tb/xbo_arbiter_bench.sv
module xbo_arbiter_bench;
  localparam int HW = 16;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_arb_en = 1'b1;
  logic hold_in = 1'b0;
  logic dma_pending = 1'b0;
  logic dma_in_frame = 1'b0;
  logic hold_out, arb_mode, local_go;
  logic [HW-1:0] host_oe;
  logic [IW-1:0] io_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xbo_arbiter #(.HOST_OE_W(HW), .IO_OE_W(IW), .SYNC_STAGES(2)) u_xbo_arbiter (
    .clk(clk), .rst(rst), .strap_arb_en(strap_arb_en), .hold_in(hold_in),
    .dma_pending(dma_pending), .dma_in_frame(dma_in_frame), .hold_out(hold_out),
    .arb_mode(arb_mode), .local_go(local_go), .host_oe(host_oe), .io_oe(io_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst = 1'b1; strap_arb_en = strap; hold_in = 1'b0;
    dma_pending = 1'b0; dma_in_frame = 1'b0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic t_reset_arbiter();
    do_reset(1'b1);
    check("R1 mode arbiter", arb_mode, 1);
    check("R2 host_oe owner", host_oe, 16'hFFFF);
    check("R2 go owner", local_go, 1);
    check("R2 hold_out owner", hold_out, 0);
    strap_arb_en = 1'b0;
    tick(5);
    check("R1 strap ignored", arb_mode, 1);
    check("R10 io_oe", io_oe, 8'hFF);
  endtask

  task automatic t_grant_release();
    do_reset(1'b1);
    tick(2);
    hold_in = 1'b1;
    tick(2);
    check("R3 no early grant", hold_out, 0);
    tick(1);
    check("R3 grant third edge", hold_out, 1);
    check("R6 host off", host_oe, 0);
    check("R6 go off", local_go, 0);
    check("R10 io on while granted", io_oe, 8'hFF);
    tick(4);
    hold_in = 1'b0;
    tick(2);
    check("R7 ack held", hold_out, 1);
    tick(1);
    check("R7 ack dropped", hold_out, 0);
    check("R7 host still off", host_oe, 0);
    check("R7 go still off", local_go, 0);
    tick(1);
    check("R7 host back", host_oe, 16'hFFFF);
    check("R7 go back", local_go, 1);
  endtask

  task automatic t_pending_block();
    do_reset(1'b1);
    dma_pending = 1'b1;
    hold_in = 1'b1;
    tick(10);
    check("R4 no grant pending", hold_out, 0);
    check("R4 go kept", local_go, 1);
    dma_pending = 1'b0;
    tick(1);
    check("R4 grant after pending", hold_out, 1);
    hold_in = 1'b0;
    tick(6);
  endtask

  task automatic t_frame_block();
    do_reset(1'b1);
    dma_in_frame = 1'b1;
    hold_in = 1'b1;
    tick(10);
    check("R5 no grant in frame", hold_out, 0);
    check("R5 host kept", host_oe, 16'hFFFF);
    dma_in_frame = 1'b0;
    tick(1);
    check("R5 grant at gap", hold_out, 1);
    hold_in = 1'b0;
    tick(6);
  endtask

  task automatic t_no_request();
    do_reset(1'b1);
    tick(20);
    check("R3 never granted without request", hold_out, 0);
  endtask

  task automatic t_slave();
    do_reset(1'b0);
    check("R1 mode slave", arb_mode, 0);
    check("R2 slave host off", host_oe, 0);
    check("R2 slave go off", local_go, 0);
    check("R2 slave hold low", hold_out, 0);
    strap_arb_en = 1'b1;
    tick(3);
    check("R1 slave strap ignored", arb_mode, 0);
    check("R10 slave io on", io_oe, 8'hFF);
    dma_pending = 1'b1;
    dma_in_frame = 1'b1;
    tick(1);
    check("R8 request raised", hold_out, 1);
    tick(5);
    check("R8 wait for grant", host_oe, 0);
    hold_in = 1'b1;
    tick(2);
    check("R8 host still off", host_oe, 0);
    tick(1);
    check("R8 host on after grant", host_oe, 16'hFFFF);
    check("R8 go on", local_go, 1);
    dma_pending = 1'b0;
    tick(4);
    check("R9 keep in frame", host_oe, 16'hFFFF);
    dma_in_frame = 1'b0;
    tick(1);
    check("R9 released hold", hold_out, 0);
    check("R9 released host", host_oe, 0);
    check("R9 released go", local_go, 0);
    dma_pending = 1'b1;
    tick(5);
    check("R9 no rerequest while grant high", hold_out, 0);
    hold_in = 1'b0;
    tick(3);
    check("R9 still low before idle", hold_out, 0);
    tick(1);
    check("R9 rerequest after grant low", hold_out, 1);
  endtask

  initial begin
    t_reset_arbiter();
    t_grant_release();
    t_pending_block();
    t_frame_block();
    t_no_request();
    t_slave();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule